// File: doc/BRIEF.md
# Sixteen-Pin GPIO Port with Edge Flags

This block is a general-purpose pin port with a small register bus. Software sets, pin by pin, whether the pin is in use, whether it drives or listens, and which level it drives. A pin that listens has its level brought through a two-flop synchroniser. That level can then be read back.

For every enabled input pin, the block records a low-to-high change in a rising-flag register and a high-to-low change in a falling-flag register. The two records are kept apart, so a downstream interrupt combiner can tell which way a pin moved and whether it has moved both ways since software last looked. The flags stay set until software clears them by writing ones.

A control bit hands pin 0 to an external logic-function output, which then drives the pad in place of the value register. The value, rising-flag and falling-flag vectors are also brought out as ports for the interrupt logic.

Top module: `gpio_edge_port`

## Requirements
- R1: After reset every register reads 0, `padOe` and `padOut` are 0, and both flag vectors are 0.
- R2: Register offsets on `busAddr`: 0 enable, 1 direction, 2 value, 3 rising flags, 4 falling flags, 5 control (bit 0 is the pin-0 mode bit). Bit i of each register belongs to pin i. Reads are combinational, bits above the pin count read 0, and offsets 6 and 7 read 0.
- R3: A pin with enable 1 and direction 1 has `padOe` 1 and `padOut` equal to its stored value bit. Every other pin has `padOe` 0 and `padOut` 0 (pin 0 is subject to R10).
- R4: Reading the value register returns the synchronised pin level for an enabled input pin, two clock edges after the pin changes. For any other pin it returns the stored value bit. `valueVec` carries the same vector.
- R5: A low-to-high change on an enabled input pin sets its rising flag at the third clock edge after the change, and not earlier.
- R6: A high-to-low change on an enabled input pin sets its falling flag at the third edge after the change. The rising flag of that pin is left as it was.
- R7: Pins that are disabled or set as outputs record no flags. Enabling an input pin whose level is already high records no edge.
- R8: Writing 1 to a bit at offset 3 or 4 clears that flag. Bits written as 0 are unchanged. A cleared flag stays clear until a new edge arrives.
- R9: If a clearing write and a new edge on the same bit fall on the same clock edge, the flag stays set.
- R10: With the pin-0 mode bit at 1, pin 0 has `padOe` 1 and `padOut` equal to `logicIrqIn`, whatever its enable and direction bits. With the mode bit at 0, pin 0 follows R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Register write strobe |
| busAddr | input | 3 | Register offset |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Combinational read data for `busAddr` |
| pinIn | input | 16 | Pad input levels |
| logicIrqIn | input | 1 | Logic-function output routed to pin 0 in mode 1 |
| padOut | output | 16 | Pad output data |
| padOe | output | 16 | Pad output enables |
| valueVec | output | 16 | Value vector seen by the bus |
| riseFlags | output | 16 | Sticky rising-edge flags |
| fallFlags | output | 16 | Sticky falling-edge flags |

## Verification
The assertions assume that `busWrEn` is low while reset is held. They also assume that pad output enables change only through register writes, so a pad driver must never be switched from outside the bus. For the one-edge-kind check, each pin must hold a level for at least one clock, so that the synchroniser never sees a rise and a fall in the same cycle. The stimulus changes `pinIn` and the bus signals only on falling clock edges. It holds each pin level for several cycles, and it keeps writes idle during reset.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

  localparam logic [2:0] OFS_ENABLE = 3'd0;
  localparam logic [2:0] OFS_DIR    = 3'd1;
  localparam logic [2:0] OFS_VALUE  = 3'd2;
  localparam logic [2:0] OFS_RISE   = 3'd3;
  localparam logic [2:0] OFS_FALL   = 3'd4;
  localparam logic [2:0] OFS_CTRL   = 3'd5;

  typedef enum logic [2:0] {
    SEL_ENABLE,
    SEL_DIR,
    SEL_VALUE,
    SEL_RISE,
    SEL_FALL,
    SEL_CTRL,
    SEL_NONE
  } rdSel_e;

  typedef struct packed {
    logic wrEnable;
    logic wrDir;
    logic wrValue;
    logic clrRise;
    logic clrFall;
    logic wrCtrl;
  } strobes_t;

endpackage

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
  import gpio_edge_pkg::*;
(
  input  logic                  busWrEn,
  input  logic [2:0]            busAddr,
  output strobes_t              strobe,
  output rdSel_e                rdSel
);

  always_comb begin
    strobe          = '0;
    strobe.wrEnable = busWrEn && (busAddr == OFS_ENABLE);
    strobe.wrDir    = busWrEn && (busAddr == OFS_DIR);
    strobe.wrValue  = busWrEn && (busAddr == OFS_VALUE);
    strobe.clrRise  = busWrEn && (busAddr == OFS_RISE);
    strobe.clrFall  = busWrEn && (busAddr == OFS_FALL);
    strobe.wrCtrl   = busWrEn && (busAddr == OFS_CTRL);
  end

  always_comb begin
    unique case (busAddr)
      OFS_ENABLE: rdSel = SEL_ENABLE;
      OFS_DIR:    rdSel = SEL_DIR;
      OFS_VALUE:  rdSel = SEL_VALUE;
      OFS_RISE:   rdSel = SEL_RISE;
      OFS_FALL:   rdSel = SEL_FALL;
      OFS_CTRL:   rdSel = SEL_CTRL;
      default:    rdSel = SEL_NONE;
    endcase
  end

endmodule

// File: rtl/gpio_edge_datapath.sv
module gpio_edge_datapath
  import gpio_edge_pkg::*;
#(
  parameter int PIN_COUNT = 16,
  parameter int BUS_W     = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobes_t             strobe,
  input  logic [PIN_COUNT-1:0] wrBits,
  input  rdSel_e               rdSel,
  input  logic [PIN_COUNT-1:0] pinIn,
  input  logic                 logicIrqIn,
  output logic [PIN_COUNT-1:0] padOut,
  output logic [PIN_COUNT-1:0] padOe,
  output logic [PIN_COUNT-1:0] valueVec,
  output logic [PIN_COUNT-1:0] riseFlags,
  output logic [PIN_COUNT-1:0] fallFlags,
  output logic [BUS_W-1:0]     rdData
);

  logic [PIN_COUNT-1:0] enReg, dirReg, valReg;
  logic                 pin0Mode;
  logic [PIN_COUNT-1:0] syncA, syncB, syncPrev;
  logic [PIN_COUNT-1:0] inputMask, riseHit, fallHit;
  logic [PIN_COUNT-1:0] riseClr, fallClr;

  // configuration registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      enReg    <= '0;
      dirReg   <= '0;
      valReg   <= '0;
      pin0Mode <= 1'b0;
    end else begin
      if (strobe.wrEnable) enReg    <= wrBits;
      if (strobe.wrDir)    dirReg   <= wrBits;
      if (strobe.wrValue)  valReg   <= wrBits;
      if (strobe.wrCtrl)   pin0Mode <= wrBits[0];
    end
  end

  // two-flop synchroniser plus history flop; tracks even disabled pins
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA    <= '0;
      syncB    <= '0;
      syncPrev <= '0;
    end else begin
      syncA    <= pinIn;
      syncB    <= syncA;
      syncPrev <= syncB;
    end
  end

  assign inputMask = enReg & ~dirReg;
  assign riseHit   = inputMask & syncB & ~syncPrev;
  assign fallHit   = inputMask & ~syncB & syncPrev;
  assign riseClr   = strobe.clrRise ? wrBits : '0;
  assign fallClr   = strobe.clrFall ? wrBits : '0;

  // sticky flags: new edge beats a same-cycle clear
  always_ff @(posedge clk) begin
    if (!rstN) begin
      riseFlags <= '0;
      fallFlags <= '0;
    end else begin
      riseFlags <= (riseFlags & ~riseClr) | riseHit;
      fallFlags <= (fallFlags & ~fallClr) | fallHit;
    end
  end

  assign valueVec = (inputMask & syncB) | (~inputMask & valReg);

  // pad drive, pin 0 may be handed to the logic-function output
  for (genvar g = 0; g < PIN_COUNT; g++) begin : g_pad
    logic gpioDrive;
    assign gpioDrive = enReg[g] & dirReg[g];
    if (g == 0) begin : g_pin0
      assign padOe[g]  = pin0Mode | gpioDrive;
      assign padOut[g] = pin0Mode ? logicIrqIn : (gpioDrive & valReg[g]);
    end else begin : g_plain
      assign padOe[g]  = gpioDrive;
      assign padOut[g] = gpioDrive & valReg[g];
    end
  end

  always_comb begin
    rdData = '0;
    unique case (rdSel)
      SEL_ENABLE: rdData[PIN_COUNT-1:0] = enReg;
      SEL_DIR:    rdData[PIN_COUNT-1:0] = dirReg;
      SEL_VALUE:  rdData[PIN_COUNT-1:0] = valueVec;
      SEL_RISE:   rdData[PIN_COUNT-1:0] = riseFlags;
      SEL_FALL:   rdData[PIN_COUNT-1:0] = fallFlags;
      SEL_CTRL:   rdData[0]             = pin0Mode;
      default:    rdData = '0;
    endcase
  end

endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port
  import gpio_edge_pkg::*;
#(
  parameter int PIN_COUNT = 16,
  parameter int BUS_W     = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busWrEn,
  input  logic [2:0]           busAddr,
  input  logic [BUS_W-1:0]     busWrData,
  output logic [BUS_W-1:0]     busRdData,
  input  logic [PIN_COUNT-1:0] pinIn,
  input  logic                 logicIrqIn,
  output logic [PIN_COUNT-1:0] padOut,
  output logic [PIN_COUNT-1:0] padOe,
  output logic [PIN_COUNT-1:0] valueVec,
  output logic [PIN_COUNT-1:0] riseFlags,
  output logic [PIN_COUNT-1:0] fallFlags
);

  strobes_t strobe;
  rdSel_e   rdSel;

  gpio_edge_ctrl u_ctrl (
    .busWrEn (busWrEn),
    .busAddr (busAddr),
    .strobe  (strobe),
    .rdSel   (rdSel)
  );

  gpio_edge_datapath #(
    .PIN_COUNT (PIN_COUNT),
    .BUS_W     (BUS_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .wrBits     (busWrData[PIN_COUNT-1:0]),
    .rdSel      (rdSel),
    .pinIn      (pinIn),
    .logicIrqIn (logicIrqIn),
    .padOut     (padOut),
    .padOe      (padOe),
    .valueVec   (valueVec),
    .riseFlags  (riseFlags),
    .fallFlags  (fallFlags),
    .rdData     (busRdData)
  );

endmodule

// File: rtl/gpio_edge_port_chk.sv
module gpio_edge_port_chk
  import gpio_edge_pkg::*;
#(
  parameter int PIN_COUNT = 16,
  parameter int BUS_W     = 32
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 busWrEn,
  input logic [2:0]           busAddr,
  input logic [BUS_W-1:0]     busWrData,
  input logic [PIN_COUNT-1:0] padOut,
  input logic [PIN_COUNT-1:0] padOe,
  input logic [PIN_COUNT-1:0] riseFlags,
  input logic [PIN_COUNT-1:0] fallFlags
);

  logic [PIN_COUNT-1:0] keepRise, keepFall;
  assign keepRise = riseFlags & ~((busWrEn && busAddr == OFS_RISE) ? busWrData[PIN_COUNT-1:0] : '0);
  assign keepFall = fallFlags & ~((busWrEn && busAddr == OFS_FALL) ? busWrData[PIN_COUNT-1:0] : '0);

  // R8: a rising flag only drops through a clearing write
  p_rise_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    (keepRise != '0) |=> ((riseFlags & $past(keepRise)) == $past(keepRise)));

  // R8: same for falling flags
  p_fall_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    (keepFall != '0) |=> ((fallFlags & $past(keepFall)) == $past(keepFall)));

  // R6: one pin never gains both flags on the same edge
  p_one_edge_kind_r6: assert property (@(posedge clk) disable iff (!rstN)
    ((riseFlags & ~$past(riseFlags)) & (fallFlags & ~$past(fallFlags))) == '0);

  // R3: output enables move only after a register write
  p_oe_by_write_r3: assert property (@(posedge clk) disable iff (!rstN)
    !$past(busWrEn) |-> $stable(padOe));

  // R3: no output data on an undriven pad
  p_out_gated_r3: assert property (@(posedge clk) disable iff (!rstN)
    (padOut & ~padOe) == '0);

endmodule

bind gpio_edge_port gpio_edge_port_chk #(
  .PIN_COUNT (PIN_COUNT),
  .BUS_W     (BUS_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busWrEn   (busWrEn),
  .busAddr   (busAddr),
  .busWrData (busWrData),
  .padOut    (padOut),
  .padOe     (padOe),
  .riseFlags (riseFlags),
  .fallFlags (fallFlags)
);

// File: tb/gpio_edge_port_tb.sv
`timescale 1ns/1ps
module gpio_edge_port_tb;

  localparam int P = 16;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rstN;
  logic         busWrEn;
  logic [2:0]   busAddr;
  logic [W-1:0] busWrData;
  logic [W-1:0] busRdData;
  logic [P-1:0] pinIn;
  logic         logicIrqIn;
  logic [P-1:0] padOut, padOe, valueVec, riseFlags, fallFlags;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  gpio_edge_port u_dut (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .pinIn(pinIn),
    .logicIrqIn(logicIrqIn), .padOut(padOut), .padOe(padOe),
    .valueVec(valueVec), .riseFlags(riseFlags), .fallFlags(fallFlags)
  );

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [2:0] a, input logic [W-1:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0; busWrData = '0;
  endtask

  task automatic busRead(input logic [2:0] a, output logic [W-1:0] d);
    @(negedge clk);
    busAddr = a;
    #0.5;
    d = busRdData;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [W-1:0] d;
    for (int a = 0; a < 6; a++) begin
      busRead(a[2:0], d);
      check("R1 reset register", d, '0);
    end
    check("R1 reset padOe", {16'h0, padOe}, '0);
    check("R1 reset padOut", {16'h0, padOut}, '0);
    check("R1 reset flags", {riseFlags, fallFlags}, '0);
  endtask

  task automatic t_regmap;
    logic [W-1:0] d;
    busWrite(3'd0, 32'hFFFF_A5C3);
    busRead(3'd0, d); check("R2 enable readback", d, 32'h0000_A5C3);
    busWrite(3'd1, 32'h0000_3C0F);
    busRead(3'd1, d); check("R2 direction readback", d, 32'h0000_3C0F);
    busWrite(3'd5, 32'h0000_0001);
    busRead(3'd5, d); check("R2 control readback", d, 32'h1);
    busWrite(3'd5, 32'h0);
    busRead(3'd6, d); check("R2 offset 6 reads 0", d, '0);
    busRead(3'd7, d); check("R2 offset 7 reads 0", d, '0);
    busWrite(3'd0, 32'h0);
    busWrite(3'd1, 32'h0);
  endtask

  task automatic t_output;
    logic [W-1:0] d;
    busWrite(3'd0, 32'h0000_00F0);
    busWrite(3'd1, 32'h0000_0F30);
    busWrite(3'd2, 32'h0000_FFAA);
    idle(1);
    check("R3 padOe only enabled outputs", {16'h0, padOe}, 32'h0000_0030);
    check("R3 padOut gated", {16'h0, padOut}, 32'h0000_0020);
    pinIn = 16'h0000;
    idle(3);
    busRead(3'd2, d);
    check("R4 value read stored bits", d, 32'h0000_FF2A);
    busWrite(3'd0, 32'h0);
    busWrite(3'd1, 32'h0);
    busWrite(3'd2, 32'h0);
  endtask

  task automatic t_input_read;
    logic [W-1:0] d;
    busWrite(3'd0, 32'h0000_0300);
    pinIn = 16'h0300;
    @(posedge clk); @(negedge clk);
    check("R4 value after one edge", {16'h0, valueVec}, 32'h0);
    @(posedge clk); @(negedge clk);
    check("R4 value after two edges", {16'h0, valueVec}, 32'h0000_0300);
    busRead(3'd2, d);
    check("R4 value register read", d, 32'h0000_0300);
    pinIn = 16'h0000;
    idle(4);
    busWrite(3'd3, 32'hFFFF);
    busWrite(3'd4, 32'hFFFF);
    busWrite(3'd0, 32'h0);
  endtask

  task automatic t_rise;
    busWrite(3'd0, 32'h0000_0008);
    idle(3);
    pinIn[3] = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check("R5 rise not after two edges", {16'h0, riseFlags}, 32'h0);
    @(posedge clk); @(negedge clk);
    check("R5 rise after third edge", {16'h0, riseFlags}, 32'h0000_0008);
    check("R5 no fall on rise", {16'h0, fallFlags}, 32'h0);
  endtask

  task automatic t_fall;
    pinIn[3] = 1'b0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check("R6 fall not after two edges", {16'h0, fallFlags}, 32'h0);
    @(posedge clk); @(negedge clk);
    check("R6 fall after third edge", {16'h0, fallFlags}, 32'h0000_0008);
    check("R6 rise flag kept", {16'h0, riseFlags}, 32'h0000_0008);
  endtask

  task automatic t_w1c;
    logic [W-1:0] d;
    busWrite(3'd3, 32'h0000_0000);
    check("R8 zero write keeps rise", {16'h0, riseFlags}, 32'h0000_0008);
    busWrite(3'd3, 32'h0000_0008);
    check("R8 rise cleared", {16'h0, riseFlags}, 32'h0);
    check("R8 fall untouched", {16'h0, fallFlags}, 32'h0000_0008);
    busWrite(3'd4, 32'h0000_FFFF);
    idle(5);
    busRead(3'd3, d);
    check("R8 stays clear with no edge", d, '0);
    busRead(3'd4, d);
    check("R8 fall cleared", d, '0);
  endtask

  task automatic t_set_wins;
    @(negedge clk);
    pinIn[3] = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = 3'd3; busWrData = 32'h0000_0008;
    @(negedge clk);
    busWrEn = 1'b0; busWrData = '0;
    check("R9 edge beats clear", {16'h0, riseFlags}, 32'h0000_0008);
    busWrite(3'd3, 32'h0000_0008);
    check("R9 later clear works", {16'h0, riseFlags}, 32'h0);
    pinIn[3] = 1'b0;
    idle(4);
    busWrite(3'd4, 32'hFFFF);
    busWrite(3'd0, 32'h0);
  endtask

  task automatic t_gating;
    busWrite(3'd0, 32'h0000_0030);
    busWrite(3'd1, 32'h0000_0020);
    pinIn[5:4] = 2'b11;
    pinIn[6]   = 1'b1;
    idle(5);
    check("R7 only enabled input flags", {16'h0, riseFlags}, 32'h0000_0010);
    pinIn[5:4] = 2'b00;
    pinIn[6]   = 1'b0;
    idle(5);
    check("R7 fall only enabled input", {16'h0, fallFlags}, 32'h0000_0010);
    busWrite(3'd3, 32'hFFFF);
    busWrite(3'd4, 32'hFFFF);
    pinIn[9] = 1'b1;
    idle(5);
    busWrite(3'd0, 32'h0000_0200);
    busWrite(3'd1, 32'h0);
    idle(5);
    check("R7 enable on high pin no edge", {riseFlags, fallFlags}, 32'h0);
    pinIn[9] = 1'b0;
    idle(5);
    busWrite(3'd4, 32'hFFFF);
    busWrite(3'd0, 32'h0);
  endtask

  task automatic t_pin0_mode;
    busWrite(3'd5, 32'h1);
    logicIrqIn = 1'b1;
    #0.5;
    check("R10 pin0 handed over oe", {31'h0, padOe[0]}, 32'h1);
    check("R10 pin0 follows logic out", {31'h0, padOut[0]}, 32'h1);
    logicIrqIn = 1'b0;
    #0.5;
    check("R10 pin0 follows logic low", {31'h0, padOut[0]}, 32'h0);
    busWrite(3'd5, 32'h0);
    logicIrqIn = 1'b1;
    #0.5;
    check("R10 mode 0 releases pin0", {30'h0, padOe[0], padOut[0]}, 32'h0);
    busWrite(3'd0, 32'h1);
    busWrite(3'd1, 32'h1);
    busWrite(3'd2, 32'h1);
    check("R10 mode 0 plain output", {30'h0, padOe[0], padOut[0]}, 32'h3);
    busWrite(3'd0, 32'h0);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    rstN = 1'b0; busWrEn = 1'b0; busAddr = '0; busWrData = '0;
    pinIn = '0; logicIrqIn = 1'b0;
    idle(4);
    rstN = 1'b1;
    idle(2);
    t_reset;
    t_regmap;
    t_output;
    t_input_read;
    t_rise;
    t_fall;
    t_w1c;
    t_set_wins;
    t_gating;
    t_pin0_mode;
    idle(3);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule